// File: doc/BRIEF.md
# Floating-point register stack controller

This block holds the eight 80-bit data registers of a floating-point coprocessor and arranges them as a rotating stack. A 3-bit top pointer, kept inside the status word, names the physical register that currently acts as stack position 0. Every command addresses registers relative to that pointer. Position i maps to physical register (top + i) mod 8. Each register carries a 2-bit tag that records what kind of value it holds or that it is empty.

The block takes five kinds of command. A load pushes a value. A store reads position 0. A store-and-pop reads position 0 and then pops. An arithmetic writeback stores a precomputed result, with its condition flags, into a chosen position and can pop afterwards. A clear command and a control-word write manage the exception state. The datapath that produces results lies outside the block.

Six sticky exception flags sit next to six mask bits in the control word. When a condition is masked, the block writes a default value and carries on. When a condition is unmasked, the command is suppressed and a handler request is raised. A stack overflow or underflow is reported as an invalid operation and also sets a separate stack-fault bit.

Top module: `fstk_ctl`

## Requirements
- R1: After reset the top pointer is 0, all eight tags read empty (tag word 0xFFFF), the flags and the stack-fault bit are 0, the control word is 0x003F (all six masks set) and the request output is low.
- R2: A load with no fault first decrements the top pointer mod 8 and then writes data_i into the new position 0. Status bits 13:11 carry the top pointer.
- R3: An arithmetic writeback with index i writes physical register (top + i) mod 8.
- R4: A plain store leaves the pointer and the tags unchanged. A store-and-pop sets the old top tag to empty (3) and increments the pointer mod 8.
- R5: An arithmetic writeback with pop_i set writes its result first, then sets the old top tag to empty and increments the pointer.
- R6: A written value gets tag 1 (zero) when its exponent and significand are both 0. It gets tag 2 (special) when its 15-bit exponent is all ones, or when the exponent is 0 and the significand is nonzero. Every other value gets tag 0 (valid). Tag g sits in tag word bits 2g+1:2g.
- R7: A stack fault sets flag bit 0 (invalid) and status bit 6. A stack fault is a load onto a non-empty register, or a store or arithmetic writeback that reads an empty operand. With the invalid mask set, a load fault still pushes and writes the indefinite value. The indefinite value has sign 1, exponent all ones and significand 0xC000000000000000. A masked store fault still pops when asked to.
- R8: An arithmetic writeback that reports divide-by-zero (flag bit 2) while control bit 2 is set writes an infinity instead of data_i. The infinity has the sign of data_i, an all-ones exponent and significand 0x8000000000000000.
- R9: A command that raises any unmasked flag writes no register and changes neither the tags nor the top pointer. Its flags are still recorded.
- R10: Flags in status bits 5:0 accumulate by OR and persist until a clear command. The clear command also zeroes the stack-fault bit.
- R11: A control write loads all 16 bits of the control word. The request output, which is also status bit 7, is high exactly when some recorded flag has its mask clear, so it follows mask changes in the next cycle.
- R12: st0_data_o shows position 0. When that register is empty, it shows the indefinite value instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | 0 none, 1 load, 2 store, 3 store-and-pop, 4 arithmetic writeback, 5 clear flags, 6 control write |
| st_idx_i | input | 3 | Stack position written by an arithmetic writeback |
| pop_i | input | 1 | Pop after an arithmetic writeback |
| data_i | input | 80 | Load operand or precomputed result |
| res_flags_i | input | 6 | Result conditions: invalid, denormal, divide-by-zero, overflow, underflow, precision (bits 0..5) |
| ctrl_i | input | 16 | Control word for a control write |
| st0_data_o | output | 80 | Value at stack position 0 |
| tag_word_o | output | 16 | Tags of the physical registers, 2 bits each |
| status_o | output | 16 | Flags 5:0, stack fault 6, request 7, top pointer 13:11 |
| ctrl_o | output | 16 | Current control word |
| exc_req_o | output | 1 | Handler request |

## Verification
The sequence first fills all eight registers so that the pointer wraps around zero. A ninth load then separates a correct overflow check from one that only compares pointer values. Stores with and without pop, and writebacks into different stack positions, show whether the relative-to-physical mapping and the pop order are right. The same divide-by-zero result is sent once with its mask set and once with it clear, which tells the default-infinity path apart from the suppress-and-request path. Draining the stack to empty and then storing checks the underflow fault and the substitute output on the read port.

// File: rtl/fstk_pkg.sv
package fstk_pkg;
  localparam int REG_W  = 80;
  localparam int EXP_W  = 15;
  localparam int MAN_W  = 64;
  localparam int NFLAG  = 6;
  localparam int CTRL_W = 16;

  localparam int F_IE = 0;
  localparam int F_ZE = 2;

  typedef enum logic [1:0] {
    TAG_VALID = 2'd0,
    TAG_ZERO  = 2'd1,
    TAG_SPEC  = 2'd2,
    TAG_EMPTY = 2'd3
  } tag_e;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_PUSH      = 3'd1,
    OP_STORE     = 3'd2,
    OP_STORE_POP = 3'd3,
    OP_ARITH     = 3'd4,
    OP_CLR       = 3'd5,
    OP_CTRL      = 3'd6,
    OP_RSV       = 3'd7
  } op_e;

  function automatic logic [1:0] classify(input logic [REG_W-1:0] v);
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] m;
    e = v[MAN_W +: EXP_W];
    m = v[MAN_W-1:0];
    if (e == '0 && m == '0) return TAG_ZERO;
    if (e == '1 || e == '0) return TAG_SPEC;
    return TAG_VALID;
  endfunction

  function automatic logic [REG_W-1:0] indef_val();
    return {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};
  endfunction

  function automatic logic [REG_W-1:0] inf_val(input logic sgn);
    return {sgn, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/fstk_regs.sv
module fstk_regs
  import fstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = REG_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [W-1:0]           wdata_i,
  input  logic                   pop_i,
  input  logic [AW-1:0]          paddr_i,
  input  logic [AW-1:0]          raddr_i,
  output logic [W-1:0]           rdata_o,
  output logic [DEPTH-1:0][1:0]  tags_o
);
  logic [W-1:0] data_q [DEPTH];
  logic [1:0]   tag_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        data_q[i] <= '0;
        tag_q[i]  <= TAG_EMPTY;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_i && waddr_i == AW'(i)) begin
          data_q[i] <= wdata_i;
          tag_q[i]  <= classify(wdata_i);
        end
        // pop wins over a same-cycle write
        if (pop_i && paddr_i == AW'(i)) tag_q[i] <= TAG_EMPTY;
      end
    end
  end

  assign rdata_o = data_q[raddr_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    assign tags_o[g] = tag_q[g];
  end

  // R4
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> tags_o[$past(paddr_i)] == TAG_EMPTY);

  // R6
  write_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !(pop_i && paddr_i == waddr_i)) |=> tags_o[$past(waddr_i)] == classify($past(wdata_i)));
endmodule

// File: rtl/fstk_exc.sv
module fstk_exc
  import fstk_pkg::*;
#(
  parameter int              NF       = NFLAG,
  parameter int              CW       = CTRL_W,
  parameter logic [CW-1:0]   CTRL_RST = CW'((1 << NF) - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          sf_set_i,
  input  logic          clr_i,
  input  logic          ctrl_we_i,
  input  logic [CW-1:0] ctrl_i,
  output logic [NF-1:0] flags_o,
  output logic          sf_o,
  output logic [CW-1:0] ctrl_o,
  output logic          req_o
);
  logic [NF-1:0] flags_q;
  logic          sf_q;
  logic [CW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      sf_q    <= 1'b0;
      ctrl_q  <= CTRL_RST;
    end else begin
      if (clr_i) begin
        flags_q <= '0;
        sf_q    <= 1'b0;
      end else begin
        flags_q <= flags_q | set_i;
        sf_q    <= sf_q | sf_set_i;
      end
      if (ctrl_we_i) ctrl_q <= ctrl_i;
    end
  end

  assign flags_o = flags_q;
  assign sf_o    = sf_q;
  assign ctrl_o  = ctrl_q;
  assign req_o   = |(flags_q & ~ctrl_q[NF-1:0]);

  // R10
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (flags_o & $past(flags_o)) == $past(flags_o));

  // R10
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> flags_o == '0 && !sf_o);

  // R11
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_o == $past(ctrl_i));
endmodule

// File: rtl/fstk_ctl.sv
module fstk_ctl
  import fstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [2:0]          cmd_op_i,
  input  logic [AW-1:0]       st_idx_i,
  input  logic                pop_i,
  input  logic [REG_W-1:0]    data_i,
  input  logic [NFLAG-1:0]    res_flags_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  output logic [REG_W-1:0]    st0_data_o,
  output logic [2*DEPTH-1:0]  tag_word_o,
  output logic [CTRL_W-1:0]   status_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                exc_req_o
);
  localparam int TOP_LSB = 11;

  logic [AW-1:0]          top_q, top_d, top_m1, dst;
  logic [DEPTH-1:0][1:0]  tags;
  logic [REG_W-1:0]       rdata;
  logic                   we, pop, sf_set, blocked, clr, ctrl_we;
  logic [AW-1:0]          waddr;
  logic [REG_W-1:0]       wdata;
  logic [NFLAG-1:0]       new_exc, flags, mask;
  logic                   sf;
  logic                   fault_push, fault_rd0, fault_dst;
  op_e                    op;

  assign op     = op_e'(cmd_op_i);
  assign top_m1 = top_q - AW'(1);
  assign dst    = top_q + st_idx_i;
  assign mask   = ctrl_o[NFLAG-1:0];

  assign fault_push = tags[top_m1] != TAG_EMPTY;
  assign fault_rd0  = tags[top_q]  == TAG_EMPTY;
  assign fault_dst  = tags[dst]    == TAG_EMPTY;

  always_comb begin
    new_exc = '0;
    sf_set  = 1'b0;
    we      = 1'b0;
    pop     = 1'b0;
    waddr   = top_q;
    wdata   = data_i;
    top_d   = top_q;
    clr     = 1'b0;
    ctrl_we = 1'b0;
    if (cmd_valid_i) begin
      unique case (op)
        OP_PUSH: begin
          new_exc[F_IE] = fault_push;
          sf_set        = fault_push;
        end
        OP_STORE, OP_STORE_POP: begin
          new_exc[F_IE] = fault_rd0;
          sf_set        = fault_rd0;
        end
        OP_ARITH: begin
          new_exc       = res_flags_i;
          new_exc[F_IE] = res_flags_i[F_IE] | fault_rd0 | fault_dst;
          sf_set        = fault_rd0 | fault_dst;
        end
        OP_CLR:  clr     = 1'b1;
        OP_CTRL: ctrl_we = 1'b1;
        default: ;
      endcase
    end
    blocked = |(new_exc & ~mask);
    if (cmd_valid_i && !blocked) begin
      unique case (op)
        OP_PUSH: begin
          we    = 1'b1;
          waddr = top_m1;
          wdata = fault_push ? indef_val() : data_i;
          top_d = top_m1;
        end
        OP_STORE_POP: begin
          pop   = 1'b1;
          top_d = top_q + AW'(1);
        end
        OP_ARITH: begin
          we    = 1'b1;
          waddr = dst;
          if (new_exc[F_IE])      wdata = indef_val();
          else if (new_exc[F_ZE]) wdata = inf_val(data_i[REG_W-1]);
          if (pop_i) begin
            pop   = 1'b1;
            top_d = top_q + AW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) top_q <= '0;
    else         top_q <= top_d;
  end

  fstk_regs #(.DEPTH(DEPTH), .W(REG_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .pop_i   (pop),
    .paddr_i (top_q),
    .raddr_i (top_q),
    .rdata_o (rdata),
    .tags_o  (tags)
  );

  fstk_exc #(.NF(NFLAG), .CW(CTRL_W)) u_exc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (new_exc),
    .sf_set_i  (sf_set),
    .clr_i     (clr),
    .ctrl_we_i (ctrl_we),
    .ctrl_i    (ctrl_i),
    .flags_o   (flags),
    .sf_o      (sf),
    .ctrl_o    (ctrl_o),
    .req_o     (exc_req_o)
  );

  assign st0_data_o = fault_rd0 ? indef_val() : rdata;
  assign tag_word_o = tags;

  always_comb begin
    status_o                   = '0;
    status_o[NFLAG-1:0]        = flags;
    status_o[6]                = sf;
    status_o[7]                = exc_req_o;
    status_o[TOP_LSB +: AW]    = top_q;
  end

  // R2
  push_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == OP_PUSH && !blocked) |=> top_q == $past(top_q) - AW'(1));

  // R9
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && blocked) |=> top_q == $past(top_q) && tags == $past(tags));

  // R4
  store_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == OP_STORE) |=> $stable(top_q) && $stable(tags));

  // R9
  req_on_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && blocked) |=> exc_req_o);
endmodule

// File: tb/fstk_ctl_test.sv
module fstk_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [79:0] INDEF = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  st_idx = 3'd0;
  logic        pop = 1'b0;
  logic [79:0] data = '0;
  logic [5:0]  res_flags = '0;
  logic [15:0] ctrl = '0;
  logic [79:0] st0_data;
  logic [15:0] tag_word, status, ctrl_out;
  logic        exc_req;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [79:0] m_data [8];
  int          m_tag  [8];
  int          m_top;
  logic [5:0]  m_flags;
  bit          m_sf;
  logic [15:0] m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  fstk_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .st_idx_i(st_idx), .pop_i(pop), .data_i(data), .res_flags_i(res_flags),
    .ctrl_i(ctrl), .st0_data_o(st0_data), .tag_word_o(tag_word),
    .status_o(status), .ctrl_o(ctrl_out), .exc_req_o(exc_req)
  );

  function automatic logic [79:0] fp(input bit s, input int e, input logic [63:0] m);
    return {s, e[14:0], m};
  endfunction

  function automatic int kind(input logic [79:0] v);
    if (v[78:0] == '0) return 1;
    if (v[78:64] == 15'h7FFF) return 2;
    if (v[78:64] == 15'h0) return 2;
    return 0;
  endfunction

  function automatic bit m_req();
    return (m_flags & ~m_ctrl[5:0]) != 6'd0;
  endfunction

  task automatic compare(input string req);
    logic [79:0] e_st0;
    logic [15:0] e_tags, e_stat;
    e_st0 = (m_tag[m_top] == 3) ? INDEF : m_data[m_top];
    e_tags = '0;
    for (int g = 0; g < 8; g++) e_tags[2*g +: 2] = m_tag[g][1:0];
    e_stat = {2'b00, m_top[2:0], 3'b000, m_req(), m_sf, m_flags};
    vectors++;
    if (st0_data !== e_st0) begin
      miscompares++;
      $display("FAIL %s st0 actual=%h expected=%h", req, st0_data, e_st0);
    end
    if (tag_word !== e_tags) begin
      miscompares++;
      $display("FAIL %s tags actual=%h expected=%h", req, tag_word, e_tags);
    end
    if (status !== e_stat) begin
      miscompares++;
      $display("FAIL %s status actual=%h expected=%h", req, status, e_stat);
    end
    if (ctrl_out !== m_ctrl || exc_req !== m_req()) begin
      miscompares++;
      $display("FAIL %s ctrl/req actual=%h/%b expected=%h/%b", req, ctrl_out, exc_req, m_ctrl, m_req());
    end
  endtask

  task automatic step(input int op, input int idx, input bit p, input logic [79:0] d,
                      input logic [5:0] rf, input logic [15:0] cw, input string req);
    int t1, dpos;
    logic [5:0] nx;
    bit f, sfl;
    logic [79:0] wv;
    cmd_valid = 1'b1; cmd_op = op[2:0]; st_idx = idx[2:0]; pop = p;
    data = d; res_flags = rf; ctrl = cw;
    // model
    nx = '0; sfl = 0;
    t1 = (m_top + 7) % 8;
    dpos = (m_top + idx) % 8;
    case (op)
      1: begin f = (m_tag[t1] != 3); nx[0] = f; sfl = f; end
      2, 3: begin f = (m_tag[m_top] == 3); nx[0] = f; sfl = f; end
      4: begin
        f = (m_tag[m_top] == 3) || (m_tag[dpos] == 3);
        nx = rf; if (f) nx[0] = 1'b1; sfl = f;
      end
      default: f = 0;
    endcase
    if ((nx & ~m_ctrl[5:0]) == 6'd0) begin
      case (op)
        1: begin
          wv = f ? INDEF : d;
          m_top = t1; m_data[t1] = wv; m_tag[t1] = kind(wv);
        end
        3: begin m_tag[m_top] = 3; m_top = (m_top + 1) % 8; end
        4: begin
          if (nx[0]) wv = INDEF;
          else if (nx[2]) wv = {d[79], 15'h7FFF, 64'h8000_0000_0000_0000};
          else wv = d;
          m_data[dpos] = wv; m_tag[dpos] = kind(wv);
          if (p) begin m_tag[m_top] = 3; m_top = (m_top + 1) % 8; end
        end
        default: ;
      endcase
    end
    if (op == 5) begin m_flags = '0; m_sf = 0; end
    else begin m_flags = m_flags | nx; m_sf = m_sf | sfl; end
    if (op == 6) m_ctrl = cw;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    compare(req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_data[i] = '0; m_tag[i] = 3; end
    m_top = 0; m_flags = '0; m_sf = 0; m_ctrl = 16'h003F;
    repeat (2) @(posedge clk);
    #1;
    compare("R1");
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1");

    // fill all eight, pointer wraps 0->7->...->0
    for (int k = 0; k < 8; k++)
      step(1, 0, 0, fp(k[0], 16383 + k, 64'h8000_0000_0000_0000 | 64'(k) << 20), 0, 0, "R2");
    // ninth load: masked overflow writes indefinite
    step(1, 0, 0, fp(0, 16390, 64'hF000_0000_0000_0000), 0, 0, "R7");
    step(5, 0, 0, '0, 0, 0, "R10");
    step(2, 0, 0, '0, 0, 0, "R4");
    step(3, 0, 0, '0, 0, 0, "R4");
    step(3, 0, 0, '0, 0, 0, "R4");
    // relative addressing and pop after writeback
    step(4, 3, 0, fp(1, 16000, 64'hA5A5_0000_0000_0001), 0, 0, "R3");
    step(4, 5, 0, fp(0, 0, 64'h0), 0, 0, "R6");
    step(4, 1, 1, fp(0, 17000, 64'h9000_0000_0000_0000), 0, 0, "R5");
    // masked divide-by-zero -> infinity, flags accumulate
    step(4, 2, 0, fp(1, 123, 64'h8000_0000_0000_0123), 6'b000100, 0, "R8");
    step(4, 0, 0, fp(0, 18000, 64'hC000_0000_0000_0002), 6'b100010, 0, "R10");
    // unmask divide-by-zero while its flag is set -> request
    step(6, 0, 0, '0, 0, 16'h033B, "R11");
    step(0, 0, 0, '0, 0, 0, "R11");
    step(5, 0, 0, '0, 0, 0, "R10");
    // unmasked divide-by-zero is suppressed
    step(4, 1, 1, fp(0, 16383, 64'h8000_0000_0000_0000), 6'b000100, 0, "R9");
    step(5, 0, 0, '0, 0, 0, "R10");
    step(6, 0, 0, '0, 0, 16'h003F, "R11");
    // drain to empty, then read an empty top
    for (int k = 0; k < 8; k++) step(3, 0, 0, '0, 0, 0, "R4");
    step(2, 0, 0, '0, 0, 0, "R12");
    step(3, 0, 0, '0, 0, 0, "R7");
    step(4, 0, 0, fp(0, 16383, 64'h8000_0000_0000_0000), 0, 0, "R7");
    step(6, 0, 0, '0, 0, 16'h003E, "R11");
    step(5, 0, 0, '0, 0, 0, "R10");
    // unmasked underflow fault blocks the writeback
    step(4, 2, 0, fp(0, 16383, 64'h8000_0000_0000_0000), 0, 0, "R9");
    step(5, 0, 0, '0, 0, 0, "R10");
    step(1, 0, 0, fp(0, 0, 64'h0000_0000_0000_0001), 0, 0, "R6");
    step(1, 0, 0, fp(1, 20000, 64'hFFFF_0000_0000_0000), 0, 0, "R2");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule